// File: doc/BRIEF.md
# DMA Channel Condition Evaluator

This block decides, for one descriptor-driven DMA channel, whether the current command should raise an interrupt, take its branch, or hold the channel in a wait. Each command carries three 2-bit policy fields, one per decision. A policy is never, always, act-if-match or act-if-no-match. The match condition compares the low device-status bits of the channel against a programmable mask and value. Each of the three policies has its own mask and value, held in its own select register.

A channel sequencer presents the command's policy bits and the live device status, then pulses `eval_strobe` when the command completes. One cycle later the branch and wait decisions appear as registered levels together with a one-cycle `dec_valid` pulse. If the interrupt decision is true, it sets a sticky interrupt line that stays high until software pulses `irq_clr`. The three select registers sit on a small word-wide register bus, which software can write and read back.

Top module: `dma_cond_unit`

## Requirements
- R1: Policy fields sit at `cmd_word` bits 5:4 (interrupt), 3:2 (branch) and 1:0 (wait). The encodings are 0 = never, 1 = act if the condition matches, 2 = act if it does not match, and 3 = always. Never always gives a false decision and always always gives a true one, whatever the status is.
- R2: The match condition is ((status[3:0] & mask) == (value & mask)). The mask is select bits 19:16 and the value is select bits 3:0. Status bits 7:4 and every other select bit have no effect.
- R3: Mode 1 decides true exactly when the condition matches, and mode 2 decides true exactly when it does not.
- R4: Bus address 0 holds the interrupt select, address 1 the branch select and address 2 the wait select. Each policy uses only its own select register, so one status can give different decisions per policy.
- R5: After reset all select registers read zero, so a mask of 0 makes every condition match.
- R6: A write with `bus_wr` high stores the full 32-bit word at `bus_addr`. `bus_rdata` shows the word stored at `bus_addr` in the same cycle. Address 3 reads zero and ignores writes.
- R7: `branch_take` and `wait_hold` are updated only in the cycle after `eval_strobe` and hold their values otherwise. `dec_valid` is high for exactly the cycle after each strobe.
- R8: `irq_level` rises in the cycle after a strobe whose interrupt decision is true, and stays high until an `irq_clr` pulse. If a set and a clear arrive in the same cycle, the set wins.
- R9: A select write in the same cycle as a strobe does not affect that evaluation. It takes effect from the next strobe onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Select register write enable |
| bus_addr | input | 2 | Select register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| cmd_word | input | 6 | Interrupt, branch and wait policy fields |
| dev_status | input | 8 | Channel device-status byte |
| eval_strobe | input | 1 | Evaluate the current command |
| irq_clr | input | 1 | Clear the sticky interrupt |
| branch_take | output | 1 | Registered branch decision |
| wait_hold | output | 1 | Registered wait decision |
| dec_valid | output | 1 | One-cycle pulse marking fresh decisions |
| irq_level | output | 1 | Sticky interrupt line |

## Verification
Register reads are combinational, so the bench checks `bus_rdata` a moment after it changes the address. A write becomes visible one edge later. Decisions, `dec_valid` and the interrupt set all appear exactly one edge after the strobe edge. The bench therefore drives each strobe on a falling edge and checks on the next falling edge, which lies after the single register stage. A sweep covers every mask, several values, all sixteen status nibbles with noisy upper bits, and all policy modes. The expected decisions are computed from the compare formula. Separate directed cases check hold-without-strobe, the set-over-clear priority and a write landing on the same edge as a strobe.

// File: rtl/dma_cond_pkg.sv
package dma_cond_pkg;

  localparam int CMP_W   = 4;
  localparam int NUM_POL = 3;
  localparam int POL_W   = 2;

  localparam int IDX_INTR   = 0;
  localparam int IDX_BRANCH = 1;
  localparam int IDX_WAIT   = 2;

  typedef enum logic [POL_W-1:0] {
    POL_NEVER  = 2'd0,
    POL_IF_SET = 2'd1,
    POL_IF_CLR = 2'd2,
    POL_ALWAYS = 2'd3
  } pol_mode_e;

  // masked compare of live status against programmed value
  function automatic logic sel_match(input logic [CMP_W-1:0] st,
                                     input logic [CMP_W-1:0] mask,
                                     input logic [CMP_W-1:0] val);
    return (st & mask) == (val & mask);
  endfunction

  // apply a policy mode to a condition
  function automatic logic pol_decide(input pol_mode_e mode, input logic cond);
    logic d;
    case (mode)
      POL_NEVER:  d = 1'b0;
      POL_IF_SET: d = cond;
      POL_IF_CLR: d = ~cond;
      default:    d = 1'b1;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/cond_sel_bank.sv
module cond_sel_bank
  import dma_cond_pkg::*;
#(
  parameter int SEL_W  = 32,
  parameter int ADDR_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [SEL_W-1:0]         wdata,
  output logic [SEL_W-1:0]         rdata,
  output logic [NUM_POL*SEL_W-1:0] sel_flat
);

  logic [SEL_W-1:0] sel_q [NUM_POL];

  for (genvar gi = 0; gi < NUM_POL; gi++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[gi] <= '0;
      end else if (wr_en && addr == ADDR_W'(gi)) begin
        sel_q[gi] <= wdata;
      end
    end
    assign sel_flat[gi*SEL_W +: SEL_W] = sel_q[gi];
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_POL; i++) begin
      if (addr == ADDR_W'(i)) rdata = sel_q[i];
    end
  end

endmodule

// File: rtl/cond_policy.sv
module cond_policy
  import dma_cond_pkg::*;
#(
  parameter int SEL_W    = 32,
  parameter int MASK_LSB = 16
) (
  input  logic [POL_W-1:0] mode,
  input  logic [CMP_W-1:0] st_cmp,
  input  logic [SEL_W-1:0] sel,
  output logic             cond,
  output logic             fire
);

  localparam int MASK_MSB = MASK_LSB + CMP_W - 1;

  logic [CMP_W-1:0] mask_f;
  logic [CMP_W-1:0] val_f;
  logic             unused_sel;

  assign mask_f     = sel[MASK_MSB:MASK_LSB];
  assign val_f      = sel[CMP_W-1:0];
  assign unused_sel = ^{sel[SEL_W-1:MASK_MSB+1], sel[MASK_LSB-1:CMP_W]};

  assign cond = sel_match(st_cmp, mask_f, val_f);
  assign fire = pol_decide(pol_mode_e'(mode), cond);

endmodule

// File: rtl/irq_hold.sv
module irq_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic level_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      level_o <= 1'b0;
    else if (set_i)  level_o <= 1'b1;
    else if (clr_i)  level_o <= 1'b0;
  end

endmodule

// File: rtl/dma_cond_unit.sv
module dma_cond_unit
  import dma_cond_pkg::*;
#(
  parameter int SEL_W    = 32,
  parameter int ADDR_W   = 2,
  parameter int STAT_W   = 8,
  parameter int MASK_LSB = 16,
  localparam int CMD_W   = NUM_POL * POL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [SEL_W-1:0]  bus_wdata,
  output logic [SEL_W-1:0]  bus_rdata,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic [STAT_W-1:0] dev_status,
  input  logic              eval_strobe,
  input  logic              irq_clr,
  output logic              branch_take,
  output logic              wait_hold,
  output logic              dec_valid,
  output logic              irq_level
);

  logic [NUM_POL*SEL_W-1:0] sel_flat;
  logic [NUM_POL-1:0]       pol_cond;
  logic [NUM_POL-1:0]       pol_fire;
  logic [CMP_W-1:0]         st_cmp;
  logic                     unused_stat;
  logic                     intr_fire;
  logic                     branch_fire;
  logic                     wait_fire;

  assign st_cmp      = dev_status[CMP_W-1:0];
  assign unused_stat = ^dev_status[STAT_W-1:CMP_W];

  cond_sel_bank #(.SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .rdata    (bus_rdata),
    .sel_flat (sel_flat)
  );

  // interrupt field is highest, wait field lowest
  for (genvar gp = 0; gp < NUM_POL; gp++) begin : g_pol
    localparam int FLD_LSB = POL_W * (NUM_POL - 1 - gp);
    cond_policy #(.SEL_W(SEL_W), .MASK_LSB(MASK_LSB)) u_pol (
      .mode   (cmd_word[FLD_LSB +: POL_W]),
      .st_cmp (st_cmp),
      .sel    (sel_flat[gp*SEL_W +: SEL_W]),
      .cond   (pol_cond[gp]),
      .fire   (pol_fire[gp])
    );
  end

  assign intr_fire   = pol_fire[IDX_INTR];
  assign branch_fire = pol_fire[IDX_BRANCH];
  assign wait_fire   = pol_fire[IDX_WAIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      branch_take <= 1'b0;
      wait_hold   <= 1'b0;
      dec_valid   <= 1'b0;
    end else begin
      dec_valid <= eval_strobe;
      if (eval_strobe) begin
        branch_take <= branch_fire;
        wait_hold   <= wait_fire;
      end
    end
  end

  irq_hold u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (eval_strobe & intr_fire),
    .clr_i   (irq_clr),
    .level_o (irq_level)
  );

endmodule

// File: rtl/dma_cond_unit_chk.sv
module dma_cond_unit_chk #(
  parameter int SEL_W  = 32,
  parameter int ADDR_W = 2,
  parameter int CMD_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [SEL_W-1:0]  bus_wdata,
  input logic [SEL_W-1:0]  bus_rdata,
  input logic [CMD_W-1:0]  cmd_word,
  input logic              eval_strobe,
  input logic              irq_clr,
  input logic              intr_fire,
  input logic              branch_take,
  input logic              wait_hold,
  input logic              dec_valid,
  input logic              irq_level
);

  assert_never_wait_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_strobe && cmd_word[1:0] == 2'd0) |=> !wait_hold);

  assert_always_branch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_strobe && cmd_word[3:2] == 2'd3) |=> branch_take);

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eval_strobe |=> dec_valid);

  assert_valid_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_strobe |=> !dec_valid);

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_strobe |=> ($stable(branch_take) && $stable(wait_hold)));

  assert_irq_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_strobe && intr_fire) |=> irq_level);

  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level && !irq_clr) |=> irq_level);

  assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !(eval_strobe && intr_fire)) |=> !irq_level);

  assert_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(0)) |=>
      (bus_addr != ADDR_W'(0) || bus_rdata == $past(bus_wdata)));

  assert_hole_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(3)) |-> (bus_rdata == '0));

endmodule

bind dma_cond_unit dma_cond_unit_chk #(
  .SEL_W(SEL_W), .ADDR_W(ADDR_W), .CMD_W(CMD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmd_word(cmd_word),
  .eval_strobe(eval_strobe), .irq_clr(irq_clr), .intr_fire(intr_fire),
  .branch_take(branch_take), .wait_hold(wait_hold), .dec_valid(dec_valid),
  .irq_level(irq_level)
);

// File: tb/dma_cond_unit_bench.sv
module dma_cond_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [5:0]  cmd_word = '0;
  logic [7:0]  dev_status = '0;
  logic        eval_strobe = 1'b0;
  logic        irq_clr = 1'b0;
  logic        branch_take, wait_hold, dec_valid, irq_level;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  dma_cond_unit u_dma_cond_unit (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmd_word(cmd_word),
    .dev_status(dev_status), .eval_strobe(eval_strobe), .irq_clr(irq_clr),
    .branch_take(branch_take), .wait_hold(wait_hold), .dec_valid(dec_valid),
    .irq_level(irq_level)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_dec(input int mode, input int st, input logic [31:0] sel);
    int m, v;
    logic c;
    m = int'(sel[19:16]);
    v = int'(sel[3:0]);
    c = ((st % 16) & m) == (v & m);
    if (mode == 0) return 1'b0;
    if (mode == 3) return 1'b1;
    if (mode == 1) return c;
    return !c;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  // strobe one evaluation, check registered results, then clear the interrupt
  task automatic eval(input string req, input logic [5:0] cmd, input logic [7:0] st,
                      input logic eb, input logic ew, input logic ei);
    @(negedge clk);
    cmd_word = cmd; dev_status = st; eval_strobe = 1'b1;
    @(negedge clk);
    eval_strobe = 1'b0;
    chk({req, " branch"}, 32'(branch_take), 32'(eb));
    chk({req, " wait"},   32'(wait_hold),   32'(ew));
    chk({req, " irq"},    32'(irq_level),   32'(ei));
    chk({req, " valid"},  32'(dec_valid),   32'd1);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] s_i, s_b, s_w, noise;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 reset state
    for (int a = 0; a < 4; a++) rd_chk("R5 reset select", 2'(a), 32'h0);
    chk("R5 reset branch", 32'(branch_take), 0);
    chk("R5 reset wait",   32'(wait_hold),   0);
    chk("R5 reset irq",    32'(irq_level),   0);
    chk("R5 reset valid",  32'(dec_valid),   0);
    eval("R5 zero mask matches", 6'b010101, 8'hC9, 1'b1, 1'b1, 1'b1);
    eval("R5 zero mask if-clear", 6'b101010, 8'h37, 1'b0, 1'b0, 1'b0);

    // R6 readback and hole
    wr(2'd1, 32'hDEAD_BEEF);
    rd_chk("R6 readback full word", 2'd1, 32'hDEAD_BEEF);
    wr(2'd3, 32'h1234_5678);
    rd_chk("R6 hole reads zero", 2'd3, 32'h0);
    rd_chk("R6 hole write ignored a0", 2'd0, 32'h0);
    rd_chk("R6 hole write ignored a1", 2'd1, 32'hDEAD_BEEF);
    rd_chk("R6 hole write ignored a2", 2'd2, 32'h0);

    // R1 R2 R3 R4 sweep
    noise = 32'hA5C3_3C50 & ~32'h000F_000F;
    for (int m = 0; m < 16; m++) begin
      for (int v = 0; v < 16; v += 5) begin
        s_i = noise | (32'(m) << 16) | 32'(v);
        s_b = noise | (32'(m ^ 5) << 16) | 32'(v ^ 3);
        s_w = noise | (32'((~m) & 15) << 16) | 32'(v ^ 12);
        wr(2'd0, s_i);
        wr(2'd1, s_b);
        wr(2'd2, s_w);
        for (int st = 0; st < 16; st++) begin
          for (int md = 0; md < 4; md++) begin
            int mi, mb, mw;
            mi = md; mb = (md + 1) % 4; mw = (md + 2) % 4;
            eval("R1 R2 R3 R4 sweep",
                 {2'(mi), 2'(mb), 2'(mw)}, {4'((st * 7) % 16), 4'(st)},
                 exp_dec(mb, st, s_b), exp_dec(mw, st, s_w), exp_dec(mi, st, s_i));
          end
        end
      end
    end

    // R7 hold without strobe
    wr(2'd1, 32'h0);
    wr(2'd2, 32'h0);
    eval("R7 load ones", 6'b001111, 8'h00, 1'b1, 1'b1, 1'b0);
    chk("R7 valid one cycle", 32'(dec_valid), 0);
    cmd_word = 6'b000000;
    repeat (3) @(negedge clk);
    chk("R7 branch held", 32'(branch_take), 1);
    chk("R7 wait held",   32'(wait_hold),   1);
    chk("R7 no valid",    32'(dec_valid),   0);

    // R8 sticky, priority, clear
    @(negedge clk);
    cmd_word = 6'b110000; eval_strobe = 1'b1; irq_clr = 1'b1;
    @(negedge clk);
    eval_strobe = 1'b0; irq_clr = 1'b0;
    chk("R8 set beats clear", 32'(irq_level), 1);
    repeat (3) @(negedge clk);
    chk("R8 sticky", 32'(irq_level), 1);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk("R8 cleared", 32'(irq_level), 0);

    // R9 write on the strobe edge
    wr(2'd1, 32'h000F_000F);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 32'h000F_0000;
    cmd_word = 6'b000100; dev_status = 8'h00; eval_strobe = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; eval_strobe = 1'b0;
    chk("R9 old select used", 32'(branch_take), 0);
    eval("R9 new select used", 6'b000100, 8'h00, 1'b1, 1'b0, 1'b0);

    finish_run();
  end

endmodule